// File: doc/BRIEF.md
# DDR SDRAM power-up initialization sequencer

This block sits on the controller side of a DDR-style SDRAM. After reset it brings the memory up by walking a fixed list of commands. It waits for the clock to settle, then issues these in order: precharge-all, extended mode load, mode load with the DLL-reset bit set, precharge-all, a run of auto refreshes, and a final mode load with the DLL-reset bit clear. The spacing between commands is held in clock cycles. Every gap is a down-counter, loaded from a parameter when a command goes out. A NOP is driven in every cycle in which no command is due.

A second counter starts when the DLL-reset command is issued. The ready flag stays low until that counter shows that the DLL lock window has passed, and until the final mode load has had its own settling gap. The mode register contents are parameters. The block forces the two bits whose meaning the sequence relies on: the DLL-enable bit of the extended register, and the DLL-reset bit of the normal register.

Command encodings on {cs_n, ras_n, cas_n, we_n}:

| Command | Encoding |
|---------|----------|
| NOP | 0111 |
| precharge | 0010 |
| auto refresh | 0001 |
| mode load | 0000 |
| read | 0101 |

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, the command pins show NOP, ba and addr are zero, and init_ready is low.
- R2: The first command after reset is released is a precharge-all (addr bit 10 = 1, every other address bit 0, ba = 0). It appears on the T_STABLE-th rising edge after release, and only NOPs come before it.
- R3: The commands come in exactly this order: precharge-all, extended mode load (ba = 1), DLL-reset mode load (ba = 0), precharge-all, N_REF auto refreshes, final mode load (ba = 0). Refresh and precharge commands carry addr = 0 apart from bit 10 of a precharge, and ba = 0.
- R4: The extended mode load carries EMR_VAL with bit 0 forced to 0, which enables the DLL. The DLL-reset mode load carries MR_VAL with bit 8 forced to 1. The final mode load carries MR_VAL with bit 8 forced to 0.
- R5: Each mode load is followed by exactly T_MRD cycles from that command to the next one, and every cycle in between is a NOP.
- R6: Each precharge-all is followed by exactly T_RP cycles to the next command, with NOPs in between.
- R7: Each auto refresh is followed by exactly T_RFC cycles to the next command, with NOPs in between.
- R8: init_ready rises in the cycle max(D + T_LOCK, F + T_MRD). Here D is the cycle of the DLL-reset mode load and F is the cycle of the final mode load.
- R9: Once init_ready is high, it stays high and only NOPs are driven until the next reset. The block never drives a read command.
- R10: A reset asserted partway through the sequence returns every output to its R1 state. After release, the whole sequence restarts from its first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | BA_W | Bank address; selects the mode register during loads |
| sdr_addr | output | ADDR_W | Address bus; carries the opcode during loads |
| init_ready | output | 1 | High once reads are permitted |

## Verification
A wrong step value in the sequencer shows up on the first command after the corruption: the command is out of order, or carries the wrong bank or opcode. A gap counter that is off by one moves the next command by one cycle, so the next command edge exposes it. A lock counter that starts late, or saturates at the wrong value, moves the rise of init_ready. That error appears only at the end of the lock window, around 200 cycles after the DLL-reset load. Before then, every command still looks correct.

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int T_STABLE = 20,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 10,
  parameter int T_LOCK   = 200,
  parameter int N_REF    = 2,
  parameter logic [ADDR_W-1:0] EMR_VAL = ADDR_W'('h000),
  parameter logic [ADDR_W-1:0] MR_VAL  = ADDR_W'('h032)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [BA_W-1:0]   sdr_ba,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic              init_ready
);

  localparam int G1   = (T_STABLE > T_RP) ? T_STABLE : T_RP;
  localparam int G2   = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int GMAX = (G1 > G2) ? G1 : G2;
  localparam int CW   = $clog2(GMAX + 1);
  localparam int LW   = $clog2(T_LOCK + 1);
  localparam int RW   = $clog2(N_REF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_RD  = 4'b0101;

  localparam logic [ADDR_W-1:0] A_PALL = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A_DLL  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] A_BIT0 = ADDR_W'(1);

  typedef enum logic [2:0] {
    S_PRE1, S_EMRS, S_MRSD, S_PRE2, S_REF, S_MRS, S_LOCK, S_DONE
  } step_t;

  step_t             step;
  logic [CW-1:0]     gap_cnt;
  logic [RW-1:0]     ref_cnt;
  logic [LW-1:0]     lock_cnt;
  logic              lock_on;
  logic [3:0]        cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ready_q;
  logic              dll_fire;

  assign dll_fire = (gap_cnt == '0) && (step == S_MRSD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= S_PRE1;
      gap_cnt <= CW'(T_STABLE - 1);
      ref_cnt <= '0;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      cmd_q  <= C_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - CW'(1);
      end else begin
        case (step)
          S_PRE1, S_PRE2: begin
            cmd_q   <= C_PRE;
            addr_q  <= A_PALL;
            gap_cnt <= CW'(T_RP - 1);
            step    <= (step == S_PRE1) ? S_EMRS : S_REF;
          end
          S_EMRS: begin
            cmd_q   <= C_MRS;
            ba_q    <= BA_W'(1);
            addr_q  <= EMR_VAL & ~A_BIT0;
            gap_cnt <= CW'(T_MRD - 1);
            step    <= S_MRSD;
          end
          S_MRSD: begin
            cmd_q   <= C_MRS;
            addr_q  <= MR_VAL | A_DLL;
            gap_cnt <= CW'(T_MRD - 1);
            step    <= S_PRE2;
          end
          S_REF: begin
            cmd_q   <= C_REF;
            gap_cnt <= CW'(T_RFC - 1);
            if (ref_cnt == RW'(N_REF - 1)) step <= S_MRS;
            else ref_cnt <= ref_cnt + RW'(1);
          end
          S_MRS: begin
            cmd_q   <= C_MRS;
            addr_q  <= MR_VAL & ~A_DLL;
            gap_cnt <= CW'(T_MRD - 1);
            step    <= S_LOCK;
          end
          S_LOCK: begin
            if (lock_cnt == LW'(T_LOCK - 1)) begin
              ready_q <= 1'b1;
              step    <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_on  <= 1'b0;
      lock_cnt <= '0;
    end else if (dll_fire) begin
      lock_on  <= 1'b1;
      lock_cnt <= '0;
    end else if (lock_on && lock_cnt != LW'(T_LOCK - 1)) begin
      lock_cnt <= lock_cnt + LW'(1);
    end
  end

  assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd_q;
  assign sdr_ba     = ba_q;
  assign sdr_addr   = addr_q;
  assign init_ready = ready_q;

  assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS && T_MRD > 1) |=> cmd_q == C_NOP);
  assert_rp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE && T_RP > 1) |=> cmd_q == C_NOP);
  assert_rfc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF && T_RFC > 1) |=> cmd_q == C_NOP);
  assert_ref_after_dll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == C_REF |-> lock_on);
  assert_lock_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (lock_on && lock_cnt == LW'(T_LOCK - 1)));
  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> (ready_q && cmd_q == C_NOP));
  assert_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q != C_RD);

endmodule

// File: tb/test_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module test_sdram_pwrup_seq;

  localparam int TS = 20, TRP = 3, TMRD = 2, TRFC = 10, TLOCK = 200, NREF = 2;
  localparam logic [12:0] EMR = 13'h003;
  localparam logic [12:0] MR  = 13'h132;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000, RD = 4'b0101;

  localparam int E_DLL = TS + TRP + TMRD;
  localparam int E_FIN = E_DLL + TMRD + TRP + NREF * TRFC;
  localparam int E_RDY = (E_DLL + TLOCK > E_FIN + TMRD) ? E_DLL + TLOCK : E_FIN + TMRD;

  // {cmd[34:31], ba[30:29], addr[28:16], gap[15:0]}
  localparam logic [34:0] SEQ [7] = '{
    {PRE, 2'd0, 13'h400, 16'(TS)},
    {MRS, 2'd1, 13'h002, 16'(TRP)},
    {MRS, 2'd0, 13'h132, 16'(TMRD)},
    {PRE, 2'd0, 13'h400, 16'(TMRD)},
    {REF, 2'd0, 13'h000, 16'(TRP)},
    {REF, 2'd0, 13'h000, 16'(TRFC)},
    {MRS, 2'd0, 13'h032, 16'(TRFC)}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, rdy;
  logic [1:0] ba;
  logic [12:0] addr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .ADDR_W(13), .BA_W(2), .T_STABLE(TS), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
    .T_LOCK(TLOCK), .N_REF(NREF), .EMR_VAL(EMR), .MR_VAL(MR)
  ) i_sdram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .sdr_cs_n(cs_n), .sdr_ras_n(ras_n), .sdr_cas_n(cas_n),
    .sdr_we_n(we_n), .sdr_ba(ba), .sdr_addr(addr), .init_ready(rdy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string gap_tag(input int i);
    case (i)
      0: return "R2 first gap";
      1, 4: return "R6 tRP gap";
      2, 3: return "R5 tMRD gap";
      default: return "R7 tRFC gap";
    endcase
  endfunction

  function automatic string cmd_tag(input int i);
    if (i == 1 || i == 2 || i == 6) return "R4 mode opcode";
    return "R3 command order";
  endfunction

  logic [18:0] got;

  initial begin
    int idx, last, rdy_at, extra;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == NOP && ba == 0 && addr == 0 && !rdy, "R1 reset state",
        {13'd0, rdy, ba, addr[3:0], cs_n, ras_n, cas_n, we_n}, {28'd0, NOP});
    rst_n = 1'b1;
    idx = 0; last = 0; rdy_at = -1; extra = 0;
    for (int cyc = 1; cyc <= E_RDY + 60; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      got = {cs_n, ras_n, cas_n, we_n, ba, addr};
      if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
        if ({cs_n, ras_n, cas_n, we_n} == RD) chk(1'b0, "R9 read issued", 32'(got), 32'(0));
        if (idx < 7) begin
          chk(got == SEQ[idx][34:16], cmd_tag(idx), 32'(got), 32'(SEQ[idx][34:16]));
          chk(cyc - last == int'(SEQ[idx][15:0]), gap_tag(idx), 32'(cyc - last), 32'(SEQ[idx][15:0]));
          last = cyc;
          idx++;
        end else begin
          extra++;
        end
      end
      if (rdy && rdy_at < 0) rdy_at = cyc;
      if (rdy_at >= 0 && !rdy) extra++;
    end
    chk(idx == 7, "R3 command count", 32'(idx), 32'd7);
    chk(rdy_at == E_RDY, "R8 ready cycle", 32'(rdy_at), 32'(E_RDY));
    chk(extra == 0 && rdy, "R9 quiet after ready", 32'(extra), 32'd0);

    // R10: reset partway through, then restart
    rst_n = 1'b0;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == NOP && !rdy, "R1 reset after ready", {31'd0, rdy}, 32'd0);
    rst_n = 1'b1;
    for (int cyc = 1; cyc <= TS + TRP + 1; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc == TS + TRP)
        chk({cs_n, ras_n, cas_n, we_n} == MRS && ba == 2'd1, "R10 second run EMRS", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, MRS});
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == NOP && ba == 0 && addr == 0 && !rdy, "R10 mid-sequence reset",
        32'({cs_n, ras_n, cas_n, we_n, ba, addr}), 32'({NOP, 15'd0}));
    @(negedge clk);
    rst_n = 1'b1;
    idx = 0;
    for (int cyc = 1; cyc <= TS; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc < TS && {cs_n, ras_n, cas_n, we_n} != NOP) idx++;
      if (cyc == TS)
        chk({cs_n, ras_n, cas_n, we_n} == PRE && addr == 13'h400 && idx == 0, "R10 restart precharge",
            {15'd0, cs_n, ras_n, cas_n, we_n, addr}, {15'd0, PRE, 13'h400});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule